// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Snoop Invalidation

This block is a small direct-mapped data cache. It sits between a processor load/store port and a main-memory port that moves one word per handshake. A parameter picks the write policy. In write-through mode every store reaches memory. In write-back mode stores stay in the cache and mark the line modified. Modified lines reach memory only when they are evicted or when a flush command asks for it.

A read miss fills the whole line one word at a time, starting at word 0. With the load-through option the requested word is returned to the processor as soon as memory delivers it, while the rest of the line is still being fetched. A flush command walks every line and writes back each modified one. Software can use it before a DMA engine reads memory.

A snoop port reports stores made by other bus masters. The controller drops any line that holds the snooped address. A modified local copy is lost in that case and is not written back. If the snoop matches the line that is being filled, the fill still finishes and the requester still gets its word, but the line is left invalid.

Top module: `dcache_ctl`

## Requirements
- R1: A read whose address is present is answered with `cpu_rvalid` high for one cycle, one clock after acceptance. The answer causes no memory transfer.
- R2: In write-through mode, a store that hits updates the cached word and performs exactly one memory write of the same address and data. No line ever becomes modified.
- R3: In write-back mode, a store that hits updates only the cached word, makes no memory transfer and marks the line modified. The data reaches memory when the line is evicted.
- R4: On a miss, a clean victim line is overwritten with no memory write. A modified victim is first written back to memory as four word writes, and only then is the new line read.
- R5: In write-through mode, a store that misses performs one memory write and no memory read, and it leaves the line that was resident in the cache untouched.
- R6: In write-back mode, a store that misses first reads the whole line. The store data is then merged into the target word and the line is marked modified, without writing memory.
- R7: A read miss fetches the four words of the line in order 0 to 3. With load-through the answer arrives while the fill is still running. Without it, the answer arrives in the cycle the controller becomes ready again.
- R8: A flush writes back every modified line and nothing else. It then raises `flush_done` for exactly one cycle, and at that point no line is modified, so a second flush writes nothing.
- R9: A snoop whose address matches a valid line invalidates that line, and a modified copy is discarded without a write-back. A snoop with a different tag leaves the line valid.
- R10: A snoop that matches the line being filled lets the fill complete and the requester receive its word, but the line stays invalid, so the next read of it misses again.
- R11: `cpu_ready` is low while an eviction, fill, write-through or flush is in progress. A memory request that is not yet accepted holds its address and direction.
- R12: After reset every line is invalid and clean, `cpu_ready` is high, and `mem_valid` and `flush_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: tag, then 4-bit line index, then 2-bit word offset |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller can accept an access |
| cpu_rvalid | output | 1 | Load data valid, one-cycle pulse |
| cpu_rdata | output | DATA_W | Load data |
| mem_valid | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle; read data is valid in the same cycle |
| mem_rdata | input | DATA_W | Memory read data |
| flush_req | input | 1 | Write back all modified lines |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| snoop_valid | input | 1 | Another master wrote `snoop_addr` |
| snoop_addr | input | ADDR_W | Word address written by the other master |

## Verification
A lost modified bit does not show up at once. It appears only at the next eviction or flush, as a missing write-back, so the bench counts memory writes around each conflict miss and each flush and compares them with the expected number. A stale valid bit shows as a hit where a miss was due: the load returns old data one cycle after acceptance and makes no memory reads, so the bench counts reads after each snoop. A wrong word counter or a wrong merge point shows up when a later load of another word of the same line returns the wrong value.

// File: rtl/dcache_pkg.sv
// Shared definitions for the data cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dcache_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,   // accepting processor accesses
        ST_EVICT,  // writing a modified victim back to memory
        ST_FILL,   // reading a line from memory
        ST_WTHRU,  // single-word store to memory
        ST_FSCAN,  // flush: inspecting one line
        ST_FWB     // flush: writing one modified line back
    } cache_st_t;

endpackage

// File: rtl/dcache_tags.sv
// Tag store with valid and modified bits per line.
// Supports a full line update, setting and clearing the modified bit, and
// snoop invalidation, which discards the line's modified state.
// Assumes: a full update and a snoop on the same line in the same cycle are
// resolved by the caller (the update wins here).
module dcache_tags #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [LINES-1:0] valid_q,
    output logic [LINES-1:0] dirty_q,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_valid,
    input  logic             upd_dirty,
    input  logic             dset_en,
    input  logic [IDX_W-1:0] dset_idx,
    input  logic             dclr_en,
    input  logic [IDX_W-1:0] dclr_idx,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic             snp_hit;

    // Read port for the controller.
    assign rd_tag = tag_q[rd_idx];

    // Snoop matches a stored valid line that is not being replaced this cycle.
    assign snp_hit = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag)
                     && !(upd_en && (upd_idx == snp_idx));

    // Tag values; need no reset because the valid bits guard them.
    always_ff @(posedge clk) begin
        if (upd_en) tag_q[upd_idx] <= upd_tag;
    end

    // Valid and modified bits; the snoop is applied last so that it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (upd_en) begin
                valid_q[upd_idx] <= upd_valid;
                dirty_q[upd_idx] <= upd_dirty;
            end
            if (dset_en) dirty_q[dset_idx] <= 1'b1;
            if (dclr_en) dirty_q[dclr_idx] <= 1'b0;
            if (snp_hit) begin
                valid_q[snp_idx] <= 1'b0;
                dirty_q[snp_idx] <= 1'b0;
            end
        end
    end

    AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |=> !valid_q[$past(snp_idx)]) else $error("snoop left line valid"); // R9

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0) && (dirty_q == '0)) else $error("lines not empty after reset"); // R12

endmodule

// File: rtl/dcache_data.sv
// Data array of the cache: one write port and one read port that is read
// combinationally.
// Assumes: the caller never reads and writes the same word in the same cycle
// and expects the new value.
module dcache_data #(
    parameter int ENTRIES = 64,
    parameter int AW      = 6,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [ENTRIES];

    // Word storage; the contents are qualified by the tag store.
    always_ff @(posedge clk) begin
        if (we) word_q[waddr] <= wdata;
    end

    // Read port.
    assign rdata = word_q[raddr];

endmodule

// File: rtl/dcache_ctl.sv
// Direct-mapped data cache controller.
// Write-through or write-back is selected by WRITE_BACK. A read miss fills
// the whole line starting at word 0, with optional early return of the
// requested word (LOAD_THROUGH). A flush writes back modified lines. A snoop
// invalidates a matching line.
// Assumes: memory read data is valid in the cycle mem_ready is high, and
// cpu_req is only sampled while cpu_ready is high.
module dcache_ctl
    import dcache_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int LINES        = 16,
    parameter int WORDS        = 4,
    parameter bit WRITE_BACK   = 1'b1,
    parameter bit LOAD_THROUGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              flush_req,
    output logic              flush_done,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int DAW   = IDX_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST_W = OFF_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] LAST_L = IDX_W'(LINES - 1);

    cache_st_t         st;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [OFF_W-1:0]  wcnt;
    logic [IDX_W-1:0]  fidx;
    logic              kill;

    logic [TAG_W-1:0]  in_tag, rq_tag, tag_rd;
    logic [IDX_W-1:0]  in_idx, rq_idx, line_sel;
    logic [OFF_W-1:0]  in_off, rq_off;
    logic [LINES-1:0]  valid_q, dirty_q;
    logic [DAW-1:0]    dat_raddr, dat_waddr;
    logic [DATA_W-1:0] dat_rd, dat_wdata;
    logic              dat_we, hit, accept, wr_hit, snp_fill, fill_last;
    logic              upd_valid, upd_dirty, dset_en, dclr_en;

    assign {in_tag, in_idx, in_off} = cpu_addr;
    assign {rq_tag, rq_idx, rq_off} = rq_addr;

    // Processor handshake and hit detection (the tag read port follows in_idx while idle).
    assign cpu_ready = (st == ST_IDLE) && !flush_req;
    assign accept    = cpu_req && cpu_ready;
    assign hit       = valid_q[in_idx] && (tag_rd == in_tag);
    assign wr_hit    = accept && cpu_we && hit;

    // Select the line for the tag read port and the word for the data read port.
    always_comb begin
        line_sel  = rq_idx;
        dat_raddr = {rq_idx, rq_off};
        case (st)
            ST_IDLE:  begin line_sel = in_idx; dat_raddr = {in_idx, in_off}; end
            ST_EVICT: dat_raddr = {rq_idx, wcnt};
            ST_FSCAN: line_sel = fidx;
            ST_FWB:   begin line_sel = fidx; dat_raddr = {fidx, wcnt}; end
            default:  ;
        endcase
    end

    // Data array write: store hits while idle, incoming words during a fill (store data merged).
    assign dat_we    = wr_hit || ((st == ST_FILL) && mem_ready);
    assign dat_waddr = (st == ST_FILL) ? {rq_idx, wcnt} : {in_idx, in_off};
    assign dat_wdata = (st != ST_FILL) ? cpu_wdata :
                       (rq_we && (wcnt == rq_off)) ? rq_wdata : mem_rdata;

    // Memory request per state.
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = rq_addr;
        mem_wdata = rq_wdata;
        case (st)
            ST_EVICT: begin mem_valid = 1'b1; mem_we = 1'b1;
                            mem_addr = {tag_rd, rq_idx, wcnt}; mem_wdata = dat_rd; end
            ST_FWB:   begin mem_valid = 1'b1; mem_we = 1'b1;
                            mem_addr = {tag_rd, fidx, wcnt}; mem_wdata = dat_rd; end
            ST_FILL:  begin mem_valid = 1'b1; mem_addr = {rq_tag, rq_idx, wcnt}; end
            ST_WTHRU: begin mem_valid = 1'b1; mem_we = 1'b1; end
            default:  ;
        endcase
    end

    // Tag store control: commit at the end of a fill, snoop kill of the filling line, modified bits.
    assign snp_fill  = snoop_valid && (st == ST_FILL)
                       && (snoop_addr[ADDR_W-1:OFF_W] == rq_addr[ADDR_W-1:OFF_W]);
    assign fill_last = (st == ST_FILL) && mem_ready && (wcnt == LAST_W);
    assign upd_valid = !(kill || snp_fill);
    assign upd_dirty = WRITE_BACK && rq_we && upd_valid;
    assign dset_en   = WRITE_BACK && wr_hit;
    assign dclr_en   = (st == ST_FWB) && mem_ready && (wcnt == LAST_W);

    dcache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(line_sel), .rd_tag(tag_rd), .valid_q(valid_q), .dirty_q(dirty_q),
        .upd_en(fill_last), .upd_idx(rq_idx), .upd_tag(rq_tag),
        .upd_valid(upd_valid), .upd_dirty(upd_dirty),
        .dset_en(dset_en), .dset_idx(in_idx),
        .dclr_en(dclr_en), .dclr_idx(fidx),
        .snp_en(snoop_valid), .snp_idx(snoop_addr[OFF_W +: IDX_W]),
        .snp_tag(snoop_addr[ADDR_W-1 -: TAG_W])
    );

    dcache_data #(.ENTRIES(LINES * WORDS), .AW(DAW), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(dat_we), .waddr(dat_waddr), .wdata(dat_wdata),
        .raddr(dat_raddr), .rdata(dat_rd)
    );

    // Sequencer: miss handling, write-through, flush walk and processor responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; rq_we <= 1'b0; rq_addr <= '0; rq_wdata <= '0;
            wcnt <= '0; fidx <= '0; kill <= 1'b0;
            cpu_rvalid <= 1'b0; cpu_rdata <= '0; flush_done <= 1'b0;
        end else begin
            cpu_rvalid <= 1'b0;
            flush_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (flush_req) begin
                        st <= ST_FSCAN; fidx <= '0;
                    end else if (accept) begin
                        rq_we <= cpu_we; rq_addr <= cpu_addr; rq_wdata <= cpu_wdata;
                        wcnt <= '0; kill <= 1'b0;
                        if (!cpu_we && hit) begin
                            cpu_rvalid <= 1'b1; cpu_rdata <= dat_rd;
                        end else if (cpu_we && (hit || !WRITE_BACK)) begin
                            if (!WRITE_BACK) st <= ST_WTHRU;
                        end else if (WRITE_BACK && valid_q[in_idx] && dirty_q[in_idx]) begin
                            st <= ST_EVICT;
                        end else begin
                            st <= ST_FILL;
                        end
                    end
                end
                ST_EVICT: if (mem_ready) begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_W) st <= ST_FILL;
                end
                ST_FILL: begin
                    if (snp_fill) kill <= 1'b1;
                    if (mem_ready) begin
                        wcnt <= wcnt + 1'b1;
                        if (LOAD_THROUGH && !rq_we && (wcnt == rq_off)) begin
                            cpu_rvalid <= 1'b1; cpu_rdata <= mem_rdata;
                        end
                        if (wcnt == LAST_W) begin
                            if (!LOAD_THROUGH && !rq_we) begin
                                cpu_rvalid <= 1'b1;
                                cpu_rdata  <= (rq_off == LAST_W) ? mem_rdata : dat_rd;
                            end
                            st <= (rq_we && !upd_valid) ? ST_WTHRU : ST_IDLE;
                        end
                    end
                end
                ST_WTHRU: if (mem_ready) st <= ST_IDLE;
                ST_FSCAN: begin
                    wcnt <= '0;
                    if (valid_q[fidx] && dirty_q[fidx]) st <= ST_FWB;
                    else if (fidx == LAST_L) begin st <= ST_IDLE; flush_done <= 1'b1; end
                    else fidx <= fidx + 1'b1;
                end
                ST_FWB: if (mem_ready) begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_W) begin
                        if (fidx == LAST_L) begin st <= ST_IDLE; flush_done <= 1'b1; end
                        else begin fidx <= fidx + 1'b1; st <= ST_FSCAN; end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we))
        else $error("memory request changed before acceptance"); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done) else $error("flush_done longer than one cycle"); // R8

    AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (dirty_q == '0)) else $error("modified line left after flush"); // R8

    AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        !WRITE_BACK |-> (dirty_q == '0)) else $error("modified line in write-through mode"); // R2

endmodule

// File: tb/dcache_ctl_bench.sv
// Scoreboard bench: instance 0 is write-back with load-through, instance 1 is
// write-through without it. Load tasks push the expected data into a queue,
// and a monitor pops it on each cpu_rvalid.
module dcache_ctl_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cpu_req [2], cpu_we [2], cpu_ready [2], cpu_rvalid [2];
    logic [AW-1:0] cpu_addr [2], mem_addr [2], snoop_addr [2];
    logic [DW-1:0] cpu_wdata [2], cpu_rdata [2], mem_wdata [2], mem_rdata [2];
    logic          mem_valid [2], mem_we [2], mem_ready [2];
    logic          flush_req [2], flush_done [2], snoop_valid [2];

    for (genvar g = 0; g < 2; g++) begin : gen_dut
        dcache_ctl #(.WRITE_BACK(g == 0), .LOAD_THROUGH(g == 0)) u_dcache_ctl (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]),
            .cpu_wdata(cpu_wdata[g]), .cpu_ready(cpu_ready[g]),
            .cpu_rvalid(cpu_rvalid[g]), .cpu_rdata(cpu_rdata[g]),
            .mem_valid(mem_valid[g]), .mem_we(mem_we[g]), .mem_addr(mem_addr[g]),
            .mem_wdata(mem_wdata[g]), .mem_ready(mem_ready[g]), .mem_rdata(mem_rdata[g]),
            .flush_req(flush_req[g]), .flush_done(flush_done[g]),
            .snoop_valid(snoop_valid[g]), .snoop_addr(snoop_addr[g])
        );
    end

    // Memory model with transfer counters.
    logic [DW-1:0] mem_arr [2][1024];
    int wr_cnt [2], rd_cnt [2], done_cnt [2];
    logic [1:0] rdy_ph = '0;

    function automatic logic [DW-1:0] f(input logic [AW-1:0] a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    function automatic logic [AW-1:0] A(input int t, input int i, input int o);
        return {10'(t), 4'(i), 2'(o)};
    endfunction

    always @(posedge clk) begin
        rdy_ph <= rdy_ph + 2'd1;
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                for (int i = 0; i < 1024; i++) mem_arr[d][i] <= f(AW'(i));
                wr_cnt[d] <= 0; rd_cnt[d] <= 0; done_cnt[d] <= 0;
            end else begin
                if (mem_valid[d] && mem_ready[d]) begin
                    if (mem_we[d]) begin
                        mem_arr[d][mem_addr[d][9:0]] <= mem_wdata[d];
                        wr_cnt[d] <= wr_cnt[d] + 1;
                    end else rd_cnt[d] <= rd_cnt[d] + 1;
                end
                if (flush_done[d]) done_cnt[d] <= done_cnt[d] + 1;
            end
        end
    end

    always_comb begin
        mem_ready[0] = (rdy_ph != 2'd3);
        mem_ready[1] = 1'b1;
        for (int d = 0; d < 2; d++) mem_rdata[d] = mem_arr[d][mem_addr[d][9:0]];
    end

    // Check bookkeeping.
    int n_chk = 0, n_err = 0;
    logic [DW-1:0] expq0 [$], expq1 [$];
    string reqq0 [$], reqq1 [$];
    logic rv_ready [2];
    logic busy_seen [2];

    task automatic chk_eq(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Monitor: pop an expected load result on every response.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                if (cpu_rvalid[d]) begin
                    rv_ready[d] = cpu_ready[d];
                    if (d == 0 && expq0.size() > 0) chk_eq(reqq0.pop_front(), cpu_rdata[0], expq0.pop_front());
                    else if (d == 1 && expq1.size() > 0) chk_eq(reqq1.pop_front(), cpu_rdata[1], expq1.pop_front());
                    else chk_eq("R1 unexpected response", 32'd1, 32'd0);
                end
            end
        end
    end

    // Driver: one processor access; loads push their expected data.
    task automatic access(input int d, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input string r);
        @(negedge clk);
        while (!cpu_ready[d]) @(negedge clk);
        cpu_req[d] = 1'b1; cpu_we[d] = we; cpu_addr[d] = a; cpu_wdata[d] = wd;
        if (!we) begin
            if (d == 0) begin expq0.push_back(wd); reqq0.push_back(r); end
            else begin expq1.push_back(wd); reqq1.push_back(r); end
        end
        @(negedge clk);
        cpu_req[d] = 1'b0; cpu_we[d] = 1'b0;
        busy_seen[d] = !cpu_ready[d];
        while (!cpu_ready[d]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic snoop(input int d, input logic [AW-1:0] a);
        @(negedge clk);
        snoop_valid[d] = 1'b1; snoop_addr[d] = a;
        @(negedge clk);
        snoop_valid[d] = 1'b0;
    endtask

    task automatic flush(input int d);
        int c0;
        c0 = done_cnt[d];
        @(negedge clk);
        while (!cpu_ready[d]) @(negedge clk);
        flush_req[d] = 1'b1;
        @(negedge clk);
        flush_req[d] = 1'b0;
        while (done_cnt[d] == c0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk_eq("R8 single done pulse", 32'(done_cnt[d] - c0), 32'd1);
    endtask

    // Load that is snooped while its line fill is running.
    task automatic load_snooped(input int d, input logic [AW-1:0] a, input logic [AW-1:0] sa);
        @(negedge clk);
        while (!cpu_ready[d]) @(negedge clk);
        cpu_req[d] = 1'b1; cpu_we[d] = 1'b0; cpu_addr[d] = a;
        if (d == 0) begin expq0.push_back(f(a)); reqq0.push_back("R10 word still delivered"); end
        else begin expq1.push_back(f(a)); reqq1.push_back("R10 word still delivered"); end
        @(negedge clk);
        cpu_req[d] = 1'b0;
        snoop_valid[d] = 1'b1; snoop_addr[d] = sa;
        @(negedge clk);
        snoop_valid[d] = 1'b0;
        while (!cpu_ready[d]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        int r0, w0;
        for (int d = 0; d < 2; d++) begin
            cpu_req[d] = 0; cpu_we[d] = 0; cpu_addr[d] = '0; cpu_wdata[d] = '0;
            flush_req[d] = 0; snoop_valid[d] = 0; snoop_addr[d] = '0;
            rv_ready[d] = 0; busy_seen[d] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R12 ready after reset", 32'(cpu_ready[0]), 32'd1);
        chk_eq("R12 no memory request", 32'(mem_valid[0]), 32'd0);
        chk_eq("R12 no done pulse", 32'(flush_done[0]), 32'd0);

        // Write-back instance with load-through.
        r0 = rd_cnt[0];
        access(0, 0, A(1, 2, 0), f(A(1, 2, 0)), "R7 miss data");
        chk_eq("R12 empty cache misses", 32'(rd_cnt[0] - r0), 32'd4);
        chk_eq("R7 early word during fill", 32'(rv_ready[0]), 32'd0);
        chk_eq("R11 stalled during fill", 32'(busy_seen[0]), 32'd1);

        r0 = rd_cnt[0];
        access(0, 0, A(1, 2, 3), f(A(1, 2, 3)), "R1 hit data");
        chk_eq("R1 hit no memory read", 32'(rd_cnt[0] - r0), 32'd0);

        w0 = wr_cnt[0]; r0 = rd_cnt[0];
        access(0, 1, A(1, 2, 1), 32'h1111_AAAA, "");
        chk_eq("R3 store hit no memory write", 32'(wr_cnt[0] - w0), 32'd0);
        access(0, 0, A(1, 2, 1), 32'h1111_AAAA, "R3 store visible");
        chk_eq("R3 no memory read", 32'(rd_cnt[0] - r0), 32'd0);

        w0 = wr_cnt[0];
        access(0, 0, A(2, 2, 0), f(A(2, 2, 0)), "R4 conflict data");
        chk_eq("R4 dirty victim written back", 32'(wr_cnt[0] - w0), 32'd4);
        chk_eq("R3 data on eviction", mem_arr[0][A(1, 2, 1)], 32'h1111_AAAA);

        w0 = wr_cnt[0]; r0 = rd_cnt[0];
        access(0, 0, A(3, 2, 2), f(A(3, 2, 2)), "R4 clean victim data");
        chk_eq("R4 clean victim no write", 32'(wr_cnt[0] - w0), 32'd0);
        chk_eq("R4 line refilled", 32'(rd_cnt[0] - r0), 32'd4);

        w0 = wr_cnt[0]; r0 = rd_cnt[0];
        access(0, 1, A(4, 5, 2), 32'h2222_BBBB, "");
        chk_eq("R6 store miss reads line", 32'(rd_cnt[0] - r0), 32'd4);
        chk_eq("R6 store miss no write", 32'(wr_cnt[0] - w0), 32'd0);
        chk_eq("R6 memory not yet updated", mem_arr[0][A(4, 5, 2)], f(A(4, 5, 2)));
        r0 = rd_cnt[0];
        access(0, 0, A(4, 5, 2), 32'h2222_BBBB, "R6 merged word");
        access(0, 0, A(4, 5, 0), f(A(4, 5, 0)), "R6 fetched neighbour");
        chk_eq("R6 line resident", 32'(rd_cnt[0] - r0), 32'd0);

        w0 = wr_cnt[0];
        flush(0);
        chk_eq("R8 flush writes dirty line", 32'(wr_cnt[0] - w0), 32'd4);
        chk_eq("R8 flushed data", mem_arr[0][A(4, 5, 2)], 32'h2222_BBBB);
        w0 = wr_cnt[0];
        flush(0);
        chk_eq("R8 second flush writes nothing", 32'(wr_cnt[0] - w0), 32'd0);

        access(0, 1, A(4, 5, 1), 32'h3333_CCCC, "");
        snoop(0, A(4, 5, 0));
        w0 = wr_cnt[0]; r0 = rd_cnt[0];
        access(0, 0, A(4, 5, 1), f(A(4, 5, 1)), "R9 local copy discarded");
        chk_eq("R9 snooped line misses", 32'(rd_cnt[0] - r0), 32'd4);
        chk_eq("R9 no write-back of discarded line", 32'(wr_cnt[0] - w0), 32'd0);
        snoop(0, A(9, 5, 0));
        r0 = rd_cnt[0];
        access(0, 0, A(4, 5, 3), f(A(4, 5, 3)), "R9 other tag ignored data");
        chk_eq("R9 other tag keeps line", 32'(rd_cnt[0] - r0), 32'd0);

        load_snooped(0, A(6, 7, 3), A(6, 7, 0));
        r0 = rd_cnt[0];
        access(0, 0, A(6, 7, 3), f(A(6, 7, 3)), "R10 reread data");
        chk_eq("R10 line left invalid", 32'(rd_cnt[0] - r0), 32'd4);

        // Write-through instance without load-through.
        access(1, 0, A(1, 3, 2), f(A(1, 3, 2)), "R7 miss data no early return");
        chk_eq("R7 answer when ready again", 32'(rv_ready[1]), 32'd1);

        w0 = wr_cnt[1]; r0 = rd_cnt[1];
        access(1, 1, A(1, 3, 2), 32'h4444_DDDD, "");
        chk_eq("R2 one memory write", 32'(wr_cnt[1] - w0), 32'd1);
        chk_eq("R2 memory updated", mem_arr[1][A(1, 3, 2)], 32'h4444_DDDD);
        access(1, 0, A(1, 3, 2), 32'h4444_DDDD, "R2 cache updated");
        chk_eq("R2 hit no read", 32'(rd_cnt[1] - r0), 32'd0);

        w0 = wr_cnt[1]; r0 = rd_cnt[1];
        access(1, 1, A(5, 3, 0), 32'h5555_EEEE, "");
        chk_eq("R5 one memory write", 32'(wr_cnt[1] - w0), 32'd1);
        chk_eq("R5 memory updated", mem_arr[1][A(5, 3, 0)], 32'h5555_EEEE);
        access(1, 0, A(1, 3, 2), 32'h4444_DDDD, "R5 resident line kept");
        chk_eq("R5 no allocation reads", 32'(rd_cnt[1] - r0), 32'd0);

        w0 = wr_cnt[1];
        flush(1);
        chk_eq("R8 write-through flush writes nothing", 32'(wr_cnt[1] - w0), 32'd0);

        chk_eq("R1 all responses seen", 32'(expq0.size() + expq1.size()), 32'd0);
        finish_run();
    end

endmodule